// File: doc/BRIEF.md
# Multi-Format Serial Receiver with Error Flags

This block receives asynchronous serial frames from a single RX line and delivers each received word through a one-entry holding register with status flags. The line is sampled once per oversample tick, with `OSR` ticks to a bit period. A 2-bit format input chooses one of four frame layouts. A start bit is accepted only if it is still low at mid-bit. Each bit value is a majority vote of the three samples around the middle of the bit, and any disagreement among those three samples is recorded as noise. The format and the parity polarity are captured when a start bit is seen, so changes during a frame do not affect it.

Once the last stop bit has been decided, the word moves into the holding register together with its frame-error and noise-error flags, and receive-full is set. A host read strobe empties the register. If a frame completes while the register is still full, the old word stays and the overrun flag is set. A separate counter watches for the line staying low for `BRK_BITS` bit periods. When that happens it sets a break flag and raises a one-cycle interrupt request.

The receive state machine has these states: IDLE, START, DATA, PARITY, STOP1, STOP2 and WAIT_HIGH. The transitions are:
- IDLE to START on a tick that sees the line low.
- START to IDLE if the mid-bit vote is high (false start).
- START to DATA if the mid-bit vote is low.
- DATA to PARITY after the last data bit in the parity format.
- DATA to STOP1 after the last data bit in every other format.
- PARITY to STOP1 once the parity bit is decided.
- STOP1 to STOP2 in the two-stop format.
- The last stop bit (STOP1, or STOP2 in the two-stop format) completes the frame. It goes to IDLE if that bit was high and to WAIT_HIGH if it was low.
- WAIT_HIGH to IDLE on a tick that sees the line high.

Top module: `uart_frame_rx`

## Requirements
- R1: After a synchronous reset, `word_o` is 0 and `full_o`, `frame_err_o`, `noise_err_o`, `overrun_o`, `break_o` and `break_irq_o` are all 0.
- R2: In format `mode_i`=00 the frame is a low start bit, 8 data bits sent LSB first, and one stop bit. `word_o[7:0]` takes the data, `word_o[8]` is 0, and `full_o` becomes 1.
- R3: In format 01 a parity bit follows the 8 data bits, then one stop bit. The expected parity bit is the XOR of the 8 data bits when `odd_par_i`=0 (even parity), and its inverse when `odd_par_i`=1 (odd parity). A mismatch sets `frame_err_o`=1.
- R4: In format 10 two stop bits follow the 8 data bits. If either stop bit is sampled low, `frame_err_o`=1.
- R5: In format 11 nine data bits are received LSB first, and the ninth bit appears on `word_o[8]`.
- R6: A stop bit sampled low at its position sets `frame_err_o`=1. The word is still delivered.
- R7: Each bit is the majority of oversample samples 7, 8 and 9, counted from 0 at the start of the bit. `noise_err_o`=1 when those three samples of any bit in the frame disagree. Samples outside 7 to 9 have no effect.
- R8: A low pulse that is high again at the mid-bit samples of the start bit produces no frame.
- R9: A one-cycle `rd_i` pulse clears `full_o`, `overrun_o` and `break_o` to 0.
- R10: A frame that completes while `full_o`=1 and no read occurs sets `overrun_o`=1 and leaves `word_o` and the error flags unchanged. `overrun_o` stays 1 until the next read.
- R11: After `BRK_BITS`×`OSR` consecutive low-line ticks, `break_irq_o` pulses for exactly one cycle and `break_o` becomes 1. There is only one pulse per continuous low period.
- R12: After a frame whose final stop bit was low, no new start bit is accepted until the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Oversample tick, one pulse per sample |
| rx_i | input | 1 | Serial input line, idle high |
| mode_i | input | 2 | Frame format: 00 8N1, 01 8-bit plus parity, 10 8-bit plus two stop bits, 11 9-bit |
| odd_par_i | input | 1 | Parity polarity: 0 even, 1 odd |
| rd_i | input | 1 | Host read strobe, empties the holding register |
| word_o | output | 9 | Received word (bit 8 is 0 except in format 11) |
| full_o | output | 1 | Holding register contains an unread word |
| frame_err_o | output | 1 | Parity or stop-bit failure of the held word |
| noise_err_o | output | 1 | Sample disagreement within the held word |
| overrun_o | output | 1 | A word was lost because the register was full |
| break_o | output | 1 | Break detected since the last read |
| break_irq_o | output | 1 | One-cycle break interrupt request |

## Verification
The bench builds the block with `OSR`=16 and `BRK_BITS`=10. Every sample position therefore maps onto one bench time slot. Single and double flips can then be placed exactly on samples 7 to 9 or outside them. The 160-tick break threshold can be probed one tick before and one tick after it fires. With the same defaults, an all-zero 8N1 frame is followed by a break inside a single 12-bit low period. That exposes the interplay between a low stop bit, the wait-for-high state and the overrun flag.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

    typedef enum logic [1:0] {
        FMT_8N1 = 2'b00,
        FMT_8P1 = 2'b01,
        FMT_8N2 = 2'b10,
        FMT_9N1 = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [8:0] word;
        logic       frame_err;
        logic       noise_err;
    } rx_frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_frame_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [1:0] mode_i,
    input  logic       odd_i,
    output logic       done_o,
    output rx_frame_t  frame_o
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] C_FIRST = CW'(MID - 1);
    localparam logic [CW-1:0] C_SECOND = CW'(MID);
    localparam logic [CW-1:0] C_DECIDE = CW'(MID + 1);
    localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

    rx_state_e       state, nxt;
    logic [CW-1:0]   cnt;
    logic            samp_a, samp_b;
    logic [3:0]      bidx;
    logic [8:0]      shreg;
    fmt_e            fmt_q;
    logic            odd_q;
    logic            par_bad, stop_bad, noisy;

    logic            at_dec, vote, disagree, start_seen, finish;
    logic [3:0]      last_idx;
    logic            exp_par;

    assign at_dec     = tick_i && (cnt == C_DECIDE);
    assign vote       = (samp_a & samp_b) | (samp_a & rx_i) | (samp_b & rx_i);
    assign disagree   = !((samp_a == samp_b) && (samp_b == rx_i));
    assign start_seen = (state == ST_IDLE) && tick_i && !rx_i;
    assign last_idx   = (fmt_q == FMT_9N1) ? 4'd8 : 4'd7;
    assign exp_par    = (^shreg[7:0]) ^ odd_q;
    assign finish     = at_dec && (((state == ST_STOP1) && (fmt_q != FMT_8N2)) ||
                                   (state == ST_STOP2));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start_seen) nxt = ST_START;
            ST_START:     if (at_dec) nxt = vote ? ST_IDLE : ST_DATA;
            ST_DATA:      if (at_dec && (bidx == last_idx))
                              nxt = (fmt_q == FMT_8P1) ? ST_PARITY : ST_STOP1;
            ST_PARITY:    if (at_dec) nxt = ST_STOP1;
            ST_STOP1:     if (at_dec) begin
                              if (fmt_q == FMT_8N2) nxt = ST_STOP2;
                              else                  nxt = vote ? ST_IDLE : ST_WAIT_HIGH;
                          end
            ST_STOP2:     if (at_dec) nxt = vote ? ST_IDLE : ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (tick_i && rx_i) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // sampling and assembly datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            samp_a   <= 1'b1;
            samp_b   <= 1'b1;
            bidx     <= '0;
            shreg    <= '0;
            fmt_q    <= FMT_8N1;
            odd_q    <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            noisy    <= 1'b0;
        end else if (start_seen) begin
            cnt      <= CW'(1);
            bidx     <= '0;
            shreg    <= '0;
            fmt_q    <= fmt_e'(mode_i);
            odd_q    <= odd_i;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            noisy    <= 1'b0;
        end else if (tick_i && (state != ST_IDLE) && (state != ST_WAIT_HIGH)) begin
            cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
            if (cnt == C_FIRST)  samp_a <= rx_i;
            if (cnt == C_SECOND) samp_b <= rx_i;
            if (at_dec) begin
                noisy <= noisy | disagree;
                unique case (state)
                    ST_DATA: begin
                        shreg[bidx] <= vote;
                        bidx        <= bidx + 4'd1;
                    end
                    ST_PARITY: if (vote != exp_par) par_bad <= 1'b1;
                    ST_STOP1, ST_STOP2: if (!vote) stop_bad <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs: one registered completion pulse with the frame contents
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                frame_o.word      <= (fmt_q == FMT_9N1) ? shreg : {1'b0, shreg[7:0]};
                frame_o.frame_err <= par_bad | stop_bad | !vote;
                frame_o.noise_err <= noisy | disagree;
            end
        end
    end
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break #(
    parameter int TICKS = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic rx_i,
    output logic irq_o
);
    localparam int W = $clog2(TICKS + 1);
    localparam logic [W-1:0] RUN_MAX = W'(TICKS);
    localparam logic [W-1:0] RUN_FIRE = W'(TICKS - 1);

    logic [W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (tick_i) begin
                if (rx_i) begin
                    run <= '0;
                end else if (run != RUN_MAX) begin
                    run <= run + W'(1);
                    if (run == RUN_FIRE) irq_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_frame_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  rx_frame_t  frame_i,
    input  logic       rd_i,
    input  logic       brk_set_i,
    output logic [8:0] word_o,
    output logic       full_o,
    output logic       ferr_o,
    output logic       nerr_o,
    output logic       ovr_o,
    output logic       brk_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            full_o <= 1'b0;
            ferr_o <= 1'b0;
            nerr_o <= 1'b0;
            ovr_o  <= 1'b0;
            brk_o  <= 1'b0;
        end else begin
            if (rd_i) begin
                full_o <= 1'b0;
                ovr_o  <= 1'b0;
                brk_o  <= 1'b0;
            end
            if (load_i) begin
                if (full_o && !rd_i) begin
                    ovr_o <= 1'b1;
                end else begin
                    word_o <= frame_i.word;
                    ferr_o <= frame_i.frame_err;
                    nerr_o <= frame_i.noise_err;
                    full_o <= 1'b1;
                end
            end
            if (brk_set_i) brk_o <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_frame_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int BRK_BITS    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [1:0] mode_i,
    input  logic       odd_par_i,
    input  logic       rd_i,
    output logic [8:0] word_o,
    output logic       full_o,
    output logic       frame_err_o,
    output logic       noise_err_o,
    output logic       overrun_o,
    output logic       break_o,
    output logic       break_irq_o
);
    localparam int BRK_TICKS = BRK_BITS * OSR;

    logic      rx_s;
    logic      frm_done;
    rx_frame_t frm;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_i),
        .dout (rx_s)
    );

    uart_rx_framer #(.OSR(OSR)) i_framer (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .rx_i    (rx_s),
        .mode_i  (mode_i),
        .odd_i   (odd_par_i),
        .done_o  (frm_done),
        .frame_o (frm)
    );

    uart_rx_break #(.TICKS(BRK_TICKS)) i_break (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .rx_i   (rx_s),
        .irq_o  (break_irq_o)
    );

    uart_rx_hold i_hold (
        .clk       (clk),
        .rst       (rst),
        .load_i    (frm_done),
        .frame_i   (frm),
        .rd_i      (rd_i),
        .brk_set_i (break_irq_o),
        .word_o    (word_o),
        .full_o    (full_o),
        .ferr_o    (frame_err_o),
        .nerr_o    (noise_err_o),
        .ovr_o     (overrun_o),
        .brk_o     (break_o)
    );
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_i,
    input logic       done,
    input logic [8:0] word_o,
    input logic       full_o,
    input logic       overrun_o,
    input logic       break_o,
    input logic       break_irq_o
);
    p_load_sets_full_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !full_o) |=> full_o);

    p_overrun_keeps_word_r10: assert property (@(posedge clk) disable iff (rst)
        (done && full_o && !rd_i) |=> (overrun_o && $stable(word_o)));

    p_overrun_needs_full_r10: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> full_o);

    p_read_empties_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !done) |=> (!full_o && !overrun_o));

    p_irq_single_r11: assert property (@(posedge clk) disable iff (rst)
        break_irq_o |=> !break_irq_o);

    p_irq_sets_break_r11: assert property (@(posedge clk) disable iff (rst)
        break_irq_o |=> break_o);
endmodule

bind uart_frame_rx uart_frame_rx_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_i        (rd_i),
    .done        (frm_done),
    .word_o      (word_o),
    .full_o      (full_o),
    .overrun_o   (overrun_o),
    .break_o     (break_o),
    .break_irq_o (break_irq_o)
);

// File: tb/test_uart_frame_rx.sv
`timescale 1ns/1ps
module test_uart_frame_rx;
    localparam int OSR = 16;
    localparam int BRK_BITS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       odd = 1'b0;
    logic       rd = 1'b0;
    logic [8:0] word_o;
    logic       full_o, frame_err_o, noise_err_o, overrun_o, break_o, break_irq_o;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;

    logic [8:0] e_word = '0;
    logic       e_full = 0, e_ferr = 0, e_nerr = 0, e_ovr = 0, e_brk = 0;

    always #2.5 clk = ~clk;

    uart_frame_rx #(.OSR(OSR), .BRK_BITS(BRK_BITS)) i_uart_frame_rx (
        .clk(clk), .rst(rst), .tick_i(tick), .rx_i(rx), .mode_i(mode),
        .odd_par_i(odd), .rd_i(rd), .word_o(word_o), .full_o(full_o),
        .frame_err_o(frame_err_o), .noise_err_o(noise_err_o),
        .overrun_o(overrun_o), .break_o(break_o), .break_irq_o(break_irq_o)
    );

    always @(negedge clk) if (!rst && break_irq_o) irq_cnt++;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, "word", int'(word_o), int'(e_word));
        chk(req, "full", int'(full_o), int'(e_full));
        chk(req, "frame_err", int'(frame_err_o), int'(e_ferr));
        chk(req, "noise_err", int'(noise_err_o), int'(e_nerr));
        chk(req, "overrun", int'(overrun_o), int'(e_ovr));
        chk(req, "break", int'(break_o), int'(e_brk));
    endtask

    // one oversample slot: line value held, exactly one tick seen by the design
    task automatic slot(logic v);
        @(negedge clk);
        tick = 1'b0;
        rx = v;
        repeat (2) @(negedge clk);
        tick = 1'b1;
    endtask

    task automatic bitp(logic v, logic [OSR-1:0] mask);
        for (int s = 0; s < OSR; s++) slot(mask[s] ? ~v : v);
    endtask

    task automatic host_read();
        @(negedge clk);
        tick = 1'b0;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        e_full = 0;
        e_ovr = 0;
        e_brk = 0;
    endtask

    // nbit: data bit index (0-based) receiving the flip mask, or -1
    task automatic send_frame(logic [1:0] m, logic [8:0] d, logic o, bit bad_par,
                              logic st1, logic st2, int nbit, logic [OSR-1:0] mask);
        int         ndata;
        logic [8:0] d_eff;
        logic [2:0] nm;
        logic       p_sent, fe, ne;
        mode = m;
        odd = o;
        ndata = (m == 2'b11) ? 9 : 8;
        p_sent = (^d[7:0]) ^ o ^ bad_par;
        d_eff = d;
        ne = 1'b0;
        bitp(1'b0, '0);
        for (int i = 0; i < ndata; i++) begin
            if (i == nbit) begin
                bitp(d[i], mask);
                nm = mask[9:7];
                if ($countones(nm) >= 2) d_eff[i] = ~d[i];
                if (nm != 3'b000 && nm != 3'b111) ne = 1'b1;
            end else begin
                bitp(d[i], '0);
            end
        end
        if (m == 2'b01) bitp(p_sent, '0);
        bitp(st1, '0);
        if (m == 2'b10) bitp(st2, '0);
        bitp(1'b1, '0);
        fe = ((m == 2'b01) && (p_sent != ((^d_eff[7:0]) ^ o))) || !st1 ||
             ((m == 2'b10) && !st2);
        if (m != 2'b11) d_eff[8] = 1'b0;
        if (e_full) begin
            e_ovr = 1;
        end else begin
            e_word = d_eff;
            e_ferr = fe;
            e_nerr = ne;
            e_full = 1;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [OSR-1:0] mk;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_all("R1");
        chk("R1", "break_irq", int'(break_irq_o), 0);

        // R2: 8N1
        send_frame(2'b00, 9'h0A5, 0, 0, 1, 1, -1, '0);
        chk_all("R2");
        host_read(); chk_all("R9");
        send_frame(2'b00, 9'h13C, 0, 0, 1, 1, -1, '0);
        chk_all("R2");
        host_read();

        // R3: parity, even and odd, good and bad
        send_frame(2'b01, 9'h037, 0, 0, 1, 1, -1, '0);
        chk_all("R3"); host_read();
        send_frame(2'b01, 9'h037, 1, 0, 1, 1, -1, '0);
        chk_all("R3"); host_read();
        send_frame(2'b01, 9'h0C1, 1, 1, 1, 1, -1, '0);
        chk("R3", "bad odd parity frame_err", int'(frame_err_o), 1);
        chk_all("R3"); host_read();
        send_frame(2'b01, 9'h0C1, 0, 1, 1, 1, -1, '0);
        chk("R3", "bad even parity frame_err", int'(frame_err_o), 1);
        host_read();

        // R4: two stop bits
        send_frame(2'b10, 9'h05A, 0, 0, 1, 1, -1, '0);
        chk_all("R4"); host_read();
        send_frame(2'b10, 9'h05A, 0, 0, 1, 0, -1, '0);
        chk("R4", "second stop low frame_err", int'(frame_err_o), 1);
        chk_all("R4"); host_read();
        send_frame(2'b10, 9'h0F0, 0, 0, 0, 1, -1, '0);
        chk("R4", "first stop low frame_err", int'(frame_err_o), 1);
        host_read();

        // R5: nine-bit word
        send_frame(2'b11, 9'h1C3, 0, 0, 1, 1, -1, '0);
        chk("R5", "word", int'(word_o), 9'h1C3);
        chk_all("R5"); host_read();

        // R6: low stop bit, word still delivered
        send_frame(2'b00, 9'h081, 0, 0, 0, 1, -1, '0);
        chk("R6", "frame_err", int'(frame_err_o), 1);
        chk_all("R6"); host_read();

        // R7: majority vote and noise flag
        mk = '0; mk[8] = 1'b1;
        send_frame(2'b00, 9'h0FF, 0, 0, 1, 1, 3, mk);
        chk("R7", "single mid flip noise", int'(noise_err_o), 1);
        chk_all("R7"); host_read();
        mk = '0; mk[7] = 1'b1; mk[9] = 1'b1;
        send_frame(2'b00, 9'h0FF, 0, 0, 1, 1, 3, mk);
        chk("R7", "double flip word", int'(word_o), 9'h0F7);
        chk_all("R7"); host_read();
        mk = '0; mk[2] = 1'b1; mk[12] = 1'b1;
        send_frame(2'b00, 9'h055, 0, 0, 1, 1, 2, mk);
        chk("R7", "edge flips ignored noise", int'(noise_err_o), 0);
        chk_all("R7"); host_read();

        // R8: false start
        for (int s = 0; s < OSR; s++) slot(s < 6 ? 1'b0 : 1'b1);
        bitp(1'b1, '0); bitp(1'b1, '0);
        chk("R8", "no frame full", int'(full_o), 0);
        chk_all("R8");

        // R10 then R9: overrun and its clearing
        send_frame(2'b00, 9'h011, 0, 0, 1, 1, -1, '0);
        send_frame(2'b00, 9'h022, 0, 0, 1, 1, -1, '0);
        chk("R10", "overrun", int'(overrun_o), 1);
        chk("R10", "old word kept", int'(word_o), 9'h011);
        chk_all("R10");
        send_frame(2'b11, 9'h133, 0, 0, 0, 1, -1, '0);
        chk("R10", "overrun sticky", int'(overrun_o), 1);
        chk_all("R10");
        host_read();
        chk("R9", "overrun cleared", int'(overrun_o), 0);
        chk_all("R9");

        // R11, R12: long low period
        irq_cnt = 0;
        mode = 2'b00;
        for (int s = 0; s < BRK_BITS * OSR; s++) slot(1'b0);
        chk("R11", "break before threshold", int'(break_o), 0);
        slot(1'b0);
        chk("R11", "break at threshold", int'(break_o), 1);
        for (int s = 0; s < 2 * OSR; s++) slot(1'b0);
        chk("R11", "one irq pulse", irq_cnt, 1);
        e_word = '0; e_full = 1; e_ferr = 1; e_nerr = 0; e_brk = 1;
        chk("R12", "no second frame overrun", int'(overrun_o), 0);
        chk_all("R12");
        bitp(1'b1, '0); bitp(1'b1, '0);
        chk_all("R12");
        host_read();
        chk("R9", "break cleared", int'(break_o), 0);
        chk_all("R9");

        // random frames against the bench model
        for (int k = 0; k < 60; k++) begin
            logic [1:0] m;
            logic [8:0] d;
            int nd, nb;
            m = 2'($urandom % 4);
            d = 9'($urandom);
            d[0] = 1'b1;
            nd = (m == 2'b11) ? 9 : 8;
            mk = '0;
            nb = -1;
            if ($urandom % 3 == 0) begin
                nb = 1 + int'($urandom % (nd - 1));
                mk[$urandom % OSR] = 1'b1;
            end
            send_frame(m, d, 1'($urandom), ($urandom % 5 == 0),
                       ($urandom % 6 != 0), ($urandom % 6 != 0), nb, mk);
            chk_all("R2,R7,R10");
            if ($urandom % 4 != 0) begin
                host_read();
                chk_all("R9");
            end
        end
        finish_run();
    end
endmodule